// File: doc/BRIEF.md
# Programmable Interrupt Controller Unit

This block gathers eight interrupt request lines, ranks them by a fixed priority and raises a single interrupt output toward a processor. Software reaches it through two byte-wide addresses. The control address takes command bytes. The data address holds the per-input mask once the unit has been set up. A request is latched on the rising edge of its input. It stays pending until an acknowledge strobe moves it into service. At that moment the unit returns an 8-bit vector built from a programmed base and the input number.

After reset the unit is unconfigured and ignores its inputs. A control write with bit 4 set opens an initialization run. The data writes that follow supply the vector base, then the cascade configuration (skipped in single mode), then the mode byte (skipped when the opening byte does not ask for it). Only after the last expected word does the data address act as the mask register. The stored cascade byte is driven out so that a pair of units can be chained by surrounding logic.

Top module: `irq_ctrl_unit`

## Requirements
- R1: After reset, irq_out is 0, the mask reads 0xFF at the data address (addr=0), the request and in-service registers are zero, and a control-address (addr=1) read returns the request register.
- R2: Until initialization completes, input edges are not recorded, irq_out stays 0, and data writes do not change the mask. The opening control byte (bit 4 set) sets the sequence: base word always, cascade word unless bit 1 is set, mode word only if bit 0 is set. The unit runs after the last expected word.
- R3: The cascade word is stored and driven on casc_cfg. It reads 0 when an initialization run skips it.
- R4: Once running, a data write loads the mask and a data read returns it. A mask bit of 1 blocks that input from raising irq_out, while its request is still recorded.
- R5: A request bit is set only by a rising edge of its input. An input held high after acknowledge does not request again.
- R6: Input 0 has the highest priority and input 7 the lowest. irq_out is 1 only when an unmasked request has higher priority than every in-service bit.
- R7: An acknowledge while irq_out is 1 sets the chosen in-service bit, clears its request bit, and one cycle later gives vec_valid=1 with vec_out = {base[7:3], index}. An acknowledge while irq_out is 0 has no effect.
- R8: A control write of exactly 0x20 clears the highest-priority in-service bit. Other control bytes with bits 4 and 3 clear leave the in-service register unchanged.
- R9: A control write of 0x0A selects the request register and 0x0B selects the in-service register for later control-address reads.
- R10: Any control write with bit 4 set clears the request and in-service registers, sets the mask to 0xFF, selects request readback, and restarts initialization.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 1 | Register address: 0 data, 1 control |
| wr_en | input | 1 | Write strobe for wr_data at addr |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte at addr (combinational) |
| irq_in | input | 8 | Interrupt request inputs, edge sensitive |
| ack | input | 1 | Interrupt acknowledge strobe |
| irq_out | output | 1 | Interrupt request to processor |
| vec_out | output | 8 | Vector of the acknowledged input |
| vec_valid | output | 1 | One-cycle pulse marking vec_out |
| casc_cfg | output | 8 | Stored cascade configuration word |

## Verification
The bench nests requests so that a lower input arrives while a higher one is in service. A design that compares against any in-service bit instead of the highest one would raise irq_out too early or never. It sends end-of-interrupt commands while two bits are in service, and sends a near-miss command byte. A design that clears the wrong bit or decodes loosely would corrupt the in-service readback. It holds an input high across an acknowledge to catch level-sensitive capture. It also re-initializes with the cascade and mode words skipped, which exposes a sequencer that counts a fixed number of words by turning the next mask write into a configuration word.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int NIN  = 8;
  localparam int IW   = $clog2(NIN);
  localparam int DW   = 8;

  typedef enum logic [2:0] {
    S_UNCONF, S_BASE, S_CASC, S_MODE, S_RUN
  } init_st_t;

  // lowest set index of v (highest priority); NIN when empty
  function automatic logic [IW:0] first_set(input logic [NIN-1:0] v);
    logic [IW:0] r;
    r = (IW+1)'(NIN);
    for (int i = NIN-1; i >= 0; i--)
      if (v[i]) r = (IW+1)'(i);
    return r;
  endfunction

  function automatic logic [DW-1:0] make_vec(input logic [DW-1:0] base,
                                             input logic [IW-1:0] idx);
    return {base[DW-1:IW], idx};
  endfunction

  function automatic logic [NIN-1:0] onehot(input logic [IW-1:0] idx);
    return NIN'(1) << idx;
  endfunction
endpackage

// File: rtl/irq_init_seq.sv
module irq_init_seq
  import irq_ctrl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          data_wr,
  input  logic [DW-1:0] wdata,
  output logic          ready,
  output logic [DW-1:0] base_q,
  output logic [DW-1:0] casc_q
);
  init_st_t st;
  logic need_casc, need_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_UNCONF;
      need_casc <= 1'b0;
      need_mode <= 1'b0;
      base_q    <= '0;
      casc_q    <= '0;
    end else if (start) begin
      st        <= S_BASE;
      need_casc <= ~wdata[1];
      need_mode <= wdata[0];
      casc_q    <= '0;
    end else if (data_wr) begin
      unique case (st)
        S_BASE: begin
          base_q <= wdata;
          st     <= need_casc ? S_CASC : (need_mode ? S_MODE : S_RUN);
        end
        S_CASC: begin
          casc_q <= wdata;
          st     <= need_mode ? S_MODE : S_RUN;
        end
        S_MODE:  st <= S_RUN;
        default: st <= st;
      endcase
    end
  end

  assign ready = (st == S_RUN);
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_ctrl_pkg::*;
(
  input  logic [NIN-1:0] irr,
  input  logic [NIN-1:0] mask,
  input  logic [NIN-1:0] isr,
  output logic [IW-1:0]  pend_idx,
  output logic           pend_any,
  output logic [IW-1:0]  svc_idx,
  output logic           svc_any,
  output logic           want_irq
);
  logic [IW:0] p_raw, s_raw;

  always_comb begin
    p_raw    = first_set(irr & ~mask);
    s_raw    = first_set(isr);
    pend_any = ~p_raw[IW];
    svc_any  = ~s_raw[IW];
    pend_idx = p_raw[IW-1:0];
    svc_idx  = s_raw[IW-1:0];
    want_irq = pend_any && (!svc_any || (p_raw < s_raw));
  end
endmodule

// File: rtl/irq_ctrl_unit.sv
module irq_ctrl_unit
  import irq_ctrl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  output logic [7:0]    rd_data,
  input  logic [7:0]    irq_in,
  input  logic          ack,
  output logic          irq_out,
  output logic [7:0]    vec_out,
  output logic          vec_valid,
  output logic [7:0]    casc_cfg
);
  logic [NIN-1:0] irr, isr, mask, irq_prev, rise;
  logic           sel_isr, ready;
  logic [DW-1:0]  base_q;
  logic [IW-1:0]  pend_idx, svc_idx;
  logic           pend_any, svc_any, want_irq;

  // named events
  logic ctrl_wr, data_wr, init_start, rdsel_cmd, eoi_fire, ack_take, mask_wr;

  assign ctrl_wr    = wr_en &  addr;
  assign data_wr    = wr_en & ~addr;
  assign init_start = ctrl_wr & wr_data[4];
  assign rdsel_cmd  = ctrl_wr & ~wr_data[4] & wr_data[3];
  assign eoi_fire   = ctrl_wr & (wr_data == 8'h20);
  assign mask_wr    = data_wr & ready;
  assign ack_take   = ack & irq_out;
  assign rise       = irq_in & ~irq_prev;

  irq_init_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(init_start), .data_wr(data_wr),
    .wdata(wr_data), .ready(ready), .base_q(base_q), .casc_q(casc_cfg)
  );

  irq_prio_pick u_pick (
    .irr(irr), .mask(mask), .isr(isr),
    .pend_idx(pend_idx), .pend_any(pend_any),
    .svc_idx(svc_idx), .svc_any(svc_any), .want_irq(want_irq)
  );

  assign irq_out = ready & want_irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr       <= '0;
      isr       <= '0;
      mask      <= '1;
      sel_isr   <= 1'b0;
      irq_prev  <= '0;
      vec_out   <= '0;
      vec_valid <= 1'b0;
    end else begin
      irq_prev  <= irq_in;
      vec_valid <= ack_take;
      if (ack_take) vec_out <= make_vec(base_q, pend_idx);
      if (init_start) begin
        irr     <= '0;
        isr     <= '0;
        mask    <= '1;
        sel_isr <= 1'b0;
      end else begin
        irr <= (irr & ~(ack_take ? onehot(pend_idx) : '0)) | (ready ? rise : '0);
        isr <= (isr & ~((eoi_fire && svc_any) ? onehot(svc_idx) : '0))
             | (ack_take ? onehot(pend_idx) : '0);
        if (mask_wr) mask <= wr_data;
        if (rdsel_cmd && wr_data[1:0] == 2'b10) sel_isr <= 1'b0;
        if (rdsel_cmd && wr_data[1:0] == 2'b11) sel_isr <= 1'b1;
      end
    end
  end

  assign rd_data = addr ? (sel_isr ? isr : irr) : mask;

  // R10: command with bit 4 set resets the register file
  p_init_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    init_start |=> (irr == '0 && isr == '0 && mask == '1));
  // R2: data writes during configuration leave the mask alone
  p_mask_hold_init_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !ready) |=> $stable(mask));
  // R6: an interrupt needs an unmasked pending request
  p_irq_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> |(irr & ~mask));
  // R7: accepted acknowledge places the input in service
  p_ack_service_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |=> (vec_valid && isr[$past(pend_idx)]));
  // R8: end-of-interrupt retires exactly one in-service bit
  p_eoi_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_fire && svc_any && !ack_take) |=>
      ($countones(isr) == $past($countones(isr)) - 1));
endmodule

// File: tb/test_irq_ctrl_unit.sv
`timescale 1ns/100ps
module test_irq_ctrl_unit;
  logic       clk = 0, rst_n = 0, addr = 0, wr_en = 0, ack = 0;
  logic [7:0] wr_data = 0, irq_in = 0;
  logic [7:0] rd_data, vec_out, casc_cfg;
  logic       irq_out, vec_valid;
  int compared = 0, mismatched = 0;
  bit done = 0;
  logic [7:0] exp_q[$];

  always #2.5 clk = ~clk;

  irq_ctrl_unit i_irq_ctrl_unit (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq_in(irq_in), .ack(ack), .irq_out(irq_out),
    .vec_out(vec_out), .vec_valid(vec_valid), .casc_cfg(casc_cfg)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk); addr = a; #1 v = rd_data;
  endtask

  task automatic pulse(input logic [7:0] bits);
    @(negedge clk); irq_in = irq_in | bits;
    @(negedge clk); irq_in = irq_in & ~bits;
  endtask

  // driver: pushes the expected vector (if any) then strobes ack
  task automatic do_ack(input bit expect_one, input logic [7:0] v);
    if (expect_one) exp_q.push_back(v);
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
  endtask

  // monitor: compares produced vectors against the queue (R7)
  always @(negedge clk) begin
    if (rst_n && vec_valid) begin
      compared++;
      if (exp_q.size() == 0) begin
        mismatched++;
        $display("FAIL R7: unexpected vector got 0x%02h expected none", vec_out);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (vec_out !== e) begin
          mismatched++;
          $display("FAIL R7: vector got 0x%02h expected 0x%02h", vec_out, e);
        end
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 irq_out", {7'b0, irq_out}, 8'h00);
    rd(0, v); chk("R1 mask", v, 8'hFF);
    rd(1, v); chk("R1 irr readback", v, 8'h00);
    // R2 edges ignored before configuration
    pulse(8'h08);
    chk("R2 irq before init", {7'b0, irq_out}, 8'h00);
    rd(1, v); chk("R2 irr before init", v, 8'h00);
    wr(0, 8'h33); rd(0, v); chk("R2 mask untouched unconfigured", v, 8'hFF);
    // full configuration run
    wr(1, 8'h11);
    rd(0, v); chk("R10 mask after start", v, 8'hFF);
    wr(0, 8'h20); wr(0, 8'h04);
    wr(0, 8'h01);
    rd(0, v); chk("R2 mode word not mask", v, 8'hFF);
    chk("R3 cascade word", casc_cfg, 8'h04);
    wr(0, 8'h00); rd(0, v); chk("R4 mask readback", v, 8'h00);
    // single request
    pulse(8'h20);
    chk("R5 irq on edge", {7'b0, irq_out}, 8'h01);
    rd(1, v); chk("R9 irr default", v, 8'h20);
    do_ack(1, 8'h25);
    chk("R7 irq after ack", {7'b0, irq_out}, 8'h00);
    rd(1, v); chk("R7 irr cleared", v, 8'h00);
    wr(1, 8'h0B); rd(1, v); chk("R9 isr select", v, 8'h20);
    // nesting
    @(negedge clk); irq_in[6] = 1;
    @(negedge clk);
    chk("R6 lower waits", {7'b0, irq_out}, 8'h00);
    pulse(8'h04);
    chk("R6 higher preempts", {7'b0, irq_out}, 8'h01);
    do_ack(1, 8'h22);
    rd(1, v); chk("R6 nested isr", v, 8'h24);
    chk("R6 blocked under 2", {7'b0, irq_out}, 8'h00);
    wr(1, 8'h20); rd(1, v); chk("R8 eoi clears highest", v, 8'h20);
    chk("R6 still blocked by 5", {7'b0, irq_out}, 8'h00);
    wr(1, 8'h20); rd(1, v); chk("R8 second eoi", v, 8'h00);
    chk("R6 released", {7'b0, irq_out}, 8'h01);
    do_ack(1, 8'h26);
    wr(1, 8'h20);
    chk("R5 held level no repeat", {7'b0, irq_out}, 8'h00);
    @(negedge clk); irq_in[6] = 0;
    // masking
    wr(0, 8'h02);
    pulse(8'h02);
    chk("R4 masked", {7'b0, irq_out}, 8'h00);
    wr(1, 8'h0A); rd(1, v); chk("R4 masked still recorded", v, 8'h02);
    wr(0, 8'h00);
    chk("R4 unmasked", {7'b0, irq_out}, 8'h01);
    do_ack(1, 8'h21);
    wr(1, 8'h0B); rd(1, v); chk("R7 isr bit1", v, 8'h02);
    wr(1, 8'h60); rd(1, v); chk("R8 near-miss ignored", v, 8'h02);
    wr(1, 8'h20); wr(1, 8'h20); rd(1, v); chk("R8 eoi on empty", v, 8'h00);
    // stray ack
    do_ack(0, 8'h00);
    rd(1, v); chk("R7 stray ack isr", v, 8'h00);
    // re-init: single mode, no mode word
    pulse(8'h10);
    wr(1, 8'h12);
    rd(0, v); chk("R10 mask set", v, 8'hFF);
    rd(1, v); chk("R10 irr cleared, irr selected", v, 8'h00);
    chk("R10 irq low", {7'b0, irq_out}, 8'h00);
    wr(0, 8'h48);
    wr(0, 8'h0F); rd(0, v); chk("R2 short sequence", v, 8'h0F);
    chk("R3 skipped cascade", casc_cfg, 8'h00);
    wr(0, 8'h00);
    pulse(8'h09);
    do_ack(1, 8'h48);
    wr(1, 8'h20);
    do_ack(1, 8'h4B);
    wr(1, 8'h20);
    pulse(8'h80);
    do_ack(1, 8'h4F);
    repeat (3) @(negedge clk);
    chk("R7 all vectors seen", 8'(exp_q.size()), 8'h00);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule